// File: doc/BRIEF.md
# Circular Request List Engine

This block is the device side of a ring-based request interface. The host sets the base addresses of two rings in host memory. The inbound ring holds request descriptors and the outbound ring holds completion tags. The host posts work by moving an inbound write index forward. The engine fetches each new inbound unit through a memory read port and hands the request address, size and unit index to a local executor. It then waits for the next one.

The executor returns completions, each carrying a flag word. For each completion the engine stores the flag into the next outbound unit, with a marker bit forced high. It then writes that unit's index to a shadow location in host memory and raises an interrupt cause. The host compares the shadow value with its own saved read index N, reads unit N+1, and reports its progress back through an acknowledge index. Both rings share one programmable entry count, and both indices wrap to 0 at that count.

Top module: `req_ring_engine`

## Requirements
- R1: Registers are selected by the word index on `reg_addr`:
  - 0/1: inbound base low/high
  - 2: inbound write index
  - 3: configuration, entry count in bits 7:0
  - 4/5: outbound base low/high
  - 6/7: shadow address low/high
  - 8: interrupt cause
  - 9: interrupt enable
  - 10: inbound read index, read-only
  - 11: outbound write index, read-only
  - 12: outbound acknowledge index

  After reset:
  - the count field is 0, which means 256 entries;
  - the four index registers (2, 10, 11, 12) read 255;
  - cause and `irq` are 0.

  A write to register 3 sets those four indices to count-1.
- R2: For each pending unit the engine issues one read at inbound base + 16 × index. In the returned data, bits 63:0 are the request address and bits 95:64 are the size. It then presents address, size and index on the request port.
- R3: Units are dispatched one at a time, in ring order, from the unit after the read index up to and including the write index. Register 10 shows the last dispatched unit.
- R4: Both indices step from count-1 to 0. A count field of 0 gives a 256-entry ring.
- R5: An accepted completion is written to outbound base + 4 × index, where index is the unit after the outbound write index. The data is the flag word OR 0x8000_0000.
- R6: After the unit write, the engine writes the same index, zero-extended, to the shadow address. It then updates register 11.
- R7: A completion is not accepted while the next outbound unit equals the acknowledge index. Acceptance resumes once the host advances register 12.
- R8: Cause bit 0 is set by every shadow write and cleared by writing 1 to it; writing 0 leaves it unchanged. `irq` is cause bit 0 AND enable bit 0.
- R9: A valid on the request port or the write port holds its payload until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mrd_valid | output | 1 | Inbound unit read request |
| mrd_ready | input | 1 | Read request accepted |
| mrd_addr | output | 64 | Address of the inbound unit |
| mrd_rvalid | input | 1 | Read data valid |
| mrd_rdata | input | 96 | Unit contents: size and address |
| req_valid | output | 1 | Request offered to the executor |
| req_ready | input | 1 | Executor takes the request |
| req_addr | output | 64 | Request address |
| req_size | output | 32 | Request size |
| req_idx | output | 8 | Inbound unit index of the request |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion accepted |
| cpl_flag | input | 32 | Flag word of the completed request |
| mwr_valid | output | 1 | Host memory write request |
| mwr_ready | input | 1 | Write accepted |
| mwr_addr | output | 64 | Write address (outbound unit or shadow) |
| mwr_data | output | 32 | Write data |
| irq | output | 1 | Outbound interrupt |

## Verification
The hardest case to reach is the full outbound ring. The full condition depends on the host acknowledge index, so it needs more completions outstanding than the ring holds minus one. The bench sets an 8-entry ring, completes three requests, and acknowledges them. It then posts seven more without acknowledging, which wraps both rings and leaves the outbound ring exactly full. Two further requests then show the completion port stalled, with no memory writes, until the acknowledge index moves.

// File: rtl/req_ring_engine.sv
`timescale 1ns/1ps
module req_ring_engine #(
  parameter int AW          = 64,
  parameter int RW          = 32,
  parameter int IDX_W       = 8,
  parameter int SIZE_W      = 32,
  parameter int FLAG_W      = 32,
  parameter int IN_UNIT_LG  = 4,
  parameter int OUT_UNIT_LG = 2,
  parameter int MARK_BIT    = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [3:0]           reg_addr,
  input  logic [RW-1:0]        reg_wdata,
  output logic [RW-1:0]        reg_rdata,
  output logic                 mrd_valid,
  input  logic                 mrd_ready,
  output logic [AW-1:0]        mrd_addr,
  input  logic                 mrd_rvalid,
  input  logic [AW+SIZE_W-1:0] mrd_rdata,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [AW-1:0]        req_addr,
  output logic [SIZE_W-1:0]    req_size,
  output logic [IDX_W-1:0]     req_idx,
  input  logic                 cpl_valid,
  output logic                 cpl_ready,
  input  logic [FLAG_W-1:0]    cpl_flag,
  output logic                 mwr_valid,
  input  logic                 mwr_ready,
  output logic [AW-1:0]        mwr_addr,
  output logic [FLAG_W-1:0]    mwr_data,
  output logic                 irq
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0]  MAX_CNT = CNT_W'(1) << IDX_W;
  localparam logic [FLAG_W-1:0] MARK    = FLAG_W'(1) << MARK_BIT;

  localparam logic [3:0] A_IB_LO = 4'd0, A_IB_HI = 4'd1, A_IB_WP = 4'd2, A_CFG  = 4'd3,
                         A_OB_LO = 4'd4, A_OB_HI = 4'd5, A_SH_LO = 4'd6, A_SH_HI = 4'd7,
                         A_CAUSE = 4'd8, A_EN    = 4'd9, A_IB_RD = 4'd10, A_OB_WR = 4'd11,
                         A_ACK   = 4'd12;

  typedef enum logic [1:0] {I_IDLE, I_RD, I_WAIT, I_DISP} in_st_t;
  typedef enum logic [1:0] {O_IDLE, O_UNIT, O_SHD} out_st_t;

  function automatic logic [CNT_W-1:0] span(input logic [IDX_W-1:0] f);
    return (f == '0) ? MAX_CNT : {1'b0, f};
  endfunction

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] s;
    s = {1'b0, i} + CNT_W'(1);
    return (s == n) ? '0 : s[IDX_W-1:0];
  endfunction

  logic [RW-1:0]     ib_lo, ib_hi, ob_lo, ob_hi, sh_lo, sh_hi;
  logic [IDX_W-1:0]  cfg_cnt, ib_wp, ib_last, ob_last, ob_ack, cur_idx, oidx;
  logic [FLAG_W-1:0] flag_q;
  logic              cause, int_en;
  in_st_t            ist;
  out_st_t           ost;

  logic              cfg_we;
  logic [CNT_W-1:0]  ring_cnt, new_cnt, new_last_w;
  logic [IDX_W-1:0]  cfg_last, ib_next, ob_next;

  assign cfg_we     = reg_we && (reg_addr == A_CFG);
  assign ring_cnt   = span(cfg_cnt);
  assign new_cnt    = span(reg_wdata[IDX_W-1:0]);
  assign new_last_w = new_cnt - CNT_W'(1);
  assign cfg_last   = new_last_w[IDX_W-1:0];
  assign ib_next    = step(ib_last, ring_cnt);
  assign ob_next    = step(ob_last, ring_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib_lo <= '0; ib_hi <= '0; ob_lo <= '0; ob_hi <= '0; sh_lo <= '0; sh_hi <= '0;
      cfg_cnt <= '0; ib_wp <= '1; ob_ack <= '1; int_en <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_IB_LO: ib_lo <= reg_wdata;
        A_IB_HI: ib_hi <= reg_wdata;
        A_OB_LO: ob_lo <= reg_wdata;
        A_OB_HI: ob_hi <= reg_wdata;
        A_SH_LO: sh_lo <= reg_wdata;
        A_SH_HI: sh_hi <= reg_wdata;
        A_IB_WP: ib_wp <= reg_wdata[IDX_W-1:0];
        A_ACK:   ob_ack <= reg_wdata[IDX_W-1:0];
        A_EN:    int_en <= reg_wdata[0];
        A_CFG: begin
          cfg_cnt <= reg_wdata[IDX_W-1:0];
          ib_wp   <= cfg_last;
          ob_ack  <= cfg_last;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_IB_LO: reg_rdata = ib_lo;
      A_IB_HI: reg_rdata = ib_hi;
      A_IB_WP: reg_rdata = RW'(ib_wp);
      A_CFG:   reg_rdata = RW'(cfg_cnt);
      A_OB_LO: reg_rdata = ob_lo;
      A_OB_HI: reg_rdata = ob_hi;
      A_SH_LO: reg_rdata = sh_lo;
      A_SH_HI: reg_rdata = sh_hi;
      A_CAUSE: reg_rdata = RW'(cause);
      A_EN:    reg_rdata = RW'(int_en);
      A_IB_RD: reg_rdata = RW'(ib_last);
      A_OB_WR: reg_rdata = RW'(ob_last);
      A_ACK:   reg_rdata = RW'(ob_ack);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist <= I_IDLE; ib_last <= '1; cur_idx <= '0; req_addr <= '0; req_size <= '0;
    end else if (cfg_we) begin
      ist <= I_IDLE; ib_last <= cfg_last;
    end else begin
      case (ist)
        I_IDLE: if (ib_last != ib_wp) begin
          cur_idx <= ib_next;
          ist     <= I_RD;
        end
        I_RD:   if (mrd_ready) ist <= I_WAIT;
        I_WAIT: if (mrd_rvalid) begin
          req_addr <= mrd_rdata[AW-1:0];
          req_size <= mrd_rdata[AW +: SIZE_W];
          ist      <= I_DISP;
        end
        I_DISP: if (req_ready) begin
          ib_last <= cur_idx;
          ist     <= I_IDLE;
        end
        default: ist <= I_IDLE;
      endcase
    end
  end

  assign mrd_valid = (ist == I_RD);
  assign mrd_addr  = AW'({ib_hi, ib_lo}) + (AW'(cur_idx) << IN_UNIT_LG);
  assign req_valid = (ist == I_DISP);
  assign req_idx   = cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ost <= O_IDLE; ob_last <= '1; oidx <= '0; flag_q <= '0; cause <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CAUSE && reg_wdata[0]) cause <= 1'b0;
      if (cfg_we) begin
        ost <= O_IDLE; ob_last <= cfg_last;
      end else begin
        case (ost)
          O_IDLE: if (cpl_valid && cpl_ready) begin
            flag_q <= cpl_flag | MARK;
            oidx   <= ob_next;
            ost    <= O_UNIT;
          end
          O_UNIT: if (mwr_ready) ost <= O_SHD;
          O_SHD:  if (mwr_ready) begin
            ob_last <= oidx;
            cause   <= 1'b1;
            ost     <= O_IDLE;
          end
          default: ost <= O_IDLE;
        endcase
      end
    end
  end

  assign cpl_ready = (ost == O_IDLE) && (ob_next != ob_ack);
  assign mwr_valid = (ost != O_IDLE);
  assign mwr_addr  = (ost == O_SHD) ? AW'({sh_hi, sh_lo})
                                    : AW'({ob_hi, ob_lo}) + (AW'(oidx) << OUT_UNIT_LG);
  assign mwr_data  = (ost == O_SHD) ? FLAG_W'(oidx) : flag_q;
  assign irq       = cause & int_en;

  a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_we) |=> (ib_last == $past(req_idx)));

  a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ib_last} < ring_cnt) && ({1'b0, ob_last} < ring_cnt));

  a_r5_marked_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready && !cfg_we) |=> (mwr_valid && mwr_data == ($past(cpl_flag) | MARK)));

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ost == O_SHD && mwr_valid) |-> (mwr_data[IDX_W-1:0] != ob_ack));

  a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ost == O_SHD && mwr_valid && mwr_ready && !cfg_we) |=> cause);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !cfg_we) |=> (req_valid && $stable(req_addr) && $stable(req_idx)));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && !mwr_ready && !cfg_we) |=> (mwr_valid && $stable(mwr_addr) && $stable(mwr_data)));
endmodule

// File: tb/req_ring_engine_bench.sv
`timescale 1ns/1ps
module req_ring_engine_bench;
  localparam logic [63:0] IN_BASE  = 64'h0000_0012_3400_0000;
  localparam logic [63:0] OUT_BASE = 64'h0000_0056_7800_0000;
  localparam logic [63:0] SHD      = 64'h0000_009A_BC00_0040;
  localparam logic [31:0] MARK     = 32'h8000_0000;
  localparam logic [3:0]  A_IB_LO = 0, A_IB_HI = 1, A_IB_WP = 2, A_CFG = 3, A_OB_LO = 4,
                          A_OB_HI = 5, A_SH_LO = 6, A_SH_HI = 7, A_CAUSE = 8, A_EN = 9,
                          A_IB_RD = 10, A_OB_WR = 11, A_ACK = 12;

  typedef struct packed { logic [63:0] a; logic [31:0] s; logic [7:0] i; } disp_t;
  typedef struct packed { logic [7:0] i; logic [31:0] d; } out_t;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mrd_valid, mrd_ready, mrd_rvalid; logic [63:0] mrd_addr; logic [95:0] mrd_rdata;
  logic req_valid, req_ready; logic [63:0] req_addr; logic [31:0] req_size; logic [7:0] req_idx;
  logic cpl_valid, cpl_ready; logic [31:0] cpl_flag;
  logic mwr_valid, mwr_ready; logic [63:0] mwr_addr; logic [31:0] mwr_data;
  logic irq;

  req_ring_engine u_req_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_idx(req_idx), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_flag(cpl_flag), .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
    .mwr_addr(mwr_addr), .mwr_data(mwr_data), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, bcnt = 256, seq = 0, shadow_cnt = 0;
  logic [7:0] wp = 8'hFF, ob_model = 8'hFF;
  logic [95:0] inb [256];
  disp_t dq[$];
  logic [31:0] cq[$];
  out_t oq[$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(logic [7:0] i);
    int s;
    s = int'(i) + 1;
    if (s == bcnt) s = 0;
    return s[7:0];
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rdchk(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, 64'(v), 64'(exp));
  endtask

  task automatic post(int n);
    for (int k = 0; k < n; k++) begin
      disp_t d;
      wp = nxt(wp);
      seq++;
      d.a = 64'h0000_00A0_0000_0000 + 64'(seq) * 64'h200;
      d.s = 32'h100 + 32'(seq) * 8;
      d.i = wp;
      inb[wp] = {d.s, d.a};
      dq.push_back(d);
    end
    wr(A_IB_WP, 32'(wp));
  endtask

  task automatic wait_shadows(int target);
    while (shadow_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    mrd_ready = 1; mrd_rvalid = 0; mrd_rdata = '0;
    forever begin
      @(negedge clk);
      if (mrd_valid) begin
        logic [63:0] off;
        off = mrd_addr - IN_BASE;
        if (dq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected fetch actual %h expected none", mrd_addr);
        end else check("R2 fetch address", mrd_addr, IN_BASE + (64'(dq[0].i) << 4));
        @(negedge clk); mrd_rvalid = 1; mrd_rdata = inb[off[11:4]];
        @(negedge clk); mrd_rvalid = 0;
      end
    end
  end

  initial begin
    int ecyc = 0;
    logic held = 0;
    logic [63:0] held_a = '0;
    req_ready = 0;
    forever begin
      @(negedge clk);
      if (held) check("R9 request held", {req_valid, req_addr[62:0]}, {1'b1, held_a[62:0]});
      ecyc++;
      req_ready = (ecyc % 3 != 0);
      held = req_valid && !req_ready;
      held_a = req_addr;
      if (req_valid && req_ready) begin
        if (dq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3: unexpected dispatch actual %h expected none", req_idx);
        end else begin
          disp_t e;
          e = dq.pop_front();
          check("R2 dispatch address", req_addr, e.a);
          check("R2 dispatch size", 64'(req_size), 64'(e.s));
          check("R3 dispatch index", 64'(req_idx), 64'(e.i));
          cq.push_back({^e.i, 7'h15, 16'hC0DE, e.i});
        end
      end
    end
  end

  initial begin
    logic hs = 0;
    cpl_valid = 0; cpl_flag = '0;
    forever begin
      @(negedge clk);
      if (hs) cpl_valid = 0;
      if (!cpl_valid && cq.size() > 0) begin
        cpl_flag = cq.pop_front();
        cpl_valid = 1;
      end
      hs = cpl_valid && cpl_ready;
      if (hs) begin
        ob_model = nxt(ob_model);
        oq.push_back('{i: ob_model, d: cpl_flag | MARK});
      end
    end
  end

  initial begin
    int wcyc = 0;
    logic phase = 0, held = 0;
    logic [63:0] held_a = '0;
    mwr_ready = 0;
    forever begin
      @(negedge clk);
      if (held) check("R9 write held", {mwr_valid, mwr_addr[62:0]}, {1'b1, held_a[62:0]});
      wcyc++;
      mwr_ready = (wcyc % 4 != 1);
      held = mwr_valid && !mwr_ready;
      held_a = mwr_addr;
      if (mwr_valid && mwr_ready) begin
        if (oq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5: unexpected write actual %h expected none", mwr_addr);
        end else if (!phase) begin
          check("R5 unit address", mwr_addr, OUT_BASE + (64'(oq[0].i) << 2));
          check("R5 unit data", 64'(mwr_data), 64'(oq[0].d));
          phase = 1;
        end else begin
          check("R6 shadow address", mwr_addr, SHD);
          check("R6 shadow value", 64'(mwr_data), 64'(oq[0].i));
          void'(oq.pop_front());
          phase = 0;
          shadow_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base_cnt;
    repeat (5) @(negedge clk);
    rst_n = 1;
    rdchk("R1 reset write index", A_IB_WP, 255);
    rdchk("R1 reset read index", A_IB_RD, 255);
    rdchk("R1 reset out index", A_OB_WR, 255);
    rdchk("R1 reset ack index", A_ACK, 255);
    rdchk("R1 reset count", A_CFG, 0);
    rdchk("R1 reset cause", A_CAUSE, 0);
    check("R1 reset irq", 64'(irq), 0);
    wr(A_IB_LO, IN_BASE[31:0]);  wr(A_IB_HI, IN_BASE[63:32]);
    wr(A_OB_LO, OUT_BASE[31:0]); wr(A_OB_HI, OUT_BASE[63:32]);
    wr(A_SH_LO, SHD[31:0]);      wr(A_SH_HI, SHD[63:32]);

    post(1);
    wait_shadows(1);
    rdchk("R4 256-entry wrap read index", A_IB_RD, 0);
    rdchk("R4 256-entry wrap out index", A_OB_WR, 0);
    rdchk("R8 cause set", A_CAUSE, 1);
    check("R8 irq masked", 64'(irq), 0);
    wr(A_EN, 1);
    check("R8 irq enabled", 64'(irq), 1);
    wr(A_CAUSE, 0);
    rdchk("R8 write zero keeps cause", A_CAUSE, 1);
    wr(A_CAUSE, 1);
    rdchk("R8 cause cleared", A_CAUSE, 0);
    check("R8 irq dropped", 64'(irq), 0);

    wr(A_CFG, 8);
    bcnt = 8; wp = 7; ob_model = 7;
    rdchk("R1 config write index", A_IB_WP, 7);
    rdchk("R1 config read index", A_IB_RD, 7);
    rdchk("R1 config out index", A_OB_WR, 7);
    rdchk("R1 config ack index", A_ACK, 7);

    base_cnt = shadow_cnt;
    post(3);
    wait_shadows(base_cnt + 3);
    rdchk("R3 read index after three", A_IB_RD, 2);
    rdchk("R6 out index after three", A_OB_WR, 2);
    check("R8 irq after updates", 64'(irq), 1);
    wr(A_ACK, 2);
    wr(A_CAUSE, 1);

    base_cnt = shadow_cnt;
    post(7);
    wait_shadows(base_cnt + 7);
    rdchk("R4 read index wrapped", A_IB_RD, 1);
    rdchk("R4 out index wrapped", A_OB_WR, 1);

    base_cnt = shadow_cnt;
    post(2);
    repeat (60) @(negedge clk);
    #1;
    check("R7 no write while full", 64'(shadow_cnt), 64'(base_cnt));
    check("R7 completion refused", 64'(cpl_ready), 0);
    check("R7 write port idle", 64'(mwr_valid), 0);
    rdchk("R3 inbound continues while full", A_IB_RD, 3);
    wr(A_ACK, 1);
    wait_shadows(base_cnt + 2);
    rdchk("R7 resumes after ack", A_OB_WR, 3);

    check("R3 all dispatched", 64'(dq.size()), 0);
    check("R5 all completed", 64'(cq.size()), 0);
    check("R6 all reported", 64'(oq.size()), 0);

    wr(A_CFG, 0);
    rdchk("R1 count zero gives 256", A_IB_RD, 255);
    finish_run();
  end
endmodule